// File: doc/BRIEF.md
# Half to Single Precision Widening Converter

This block turns a 16-bit half-precision floating-point word into the single-precision word with the same value. Every half value has an exact single-precision equivalent, so the block never rounds. Its work is to re-bias the exponent and left-align the fraction. It also classifies the special encodings, and it fully normalises half subnormals into ordinary single-precision normals by locating their leading one and shifting it out.

A mode input selects between two half formats. In the standard format the all-ones exponent code means infinity (zero fraction) or NaN (non-zero fraction). In the extended-range format that code is an ordinary exponent, so those inputs decode to normal values from 65536 up to 131008, and no input is infinity or NaN. A parameter adds one output register, cleared by an active-low asynchronous reset. When that parameter is off the block is purely combinational.

Top module: `fp16_to_fp32_widen`

## Requirements
- R1: A half input with stored exponent e in 1..30 (bits 14:10, bias 15; sign in bit 15, fraction in bits 9:0) gives an output with biased exponent e+112 in bits 30:23, the 10 input fraction bits in output bits 22:13, and zeros in bits 12:0. Examples: 0x3C00 gives 0x3F800000, 0x7BFF gives 0x477FE000, 0xC000 gives 0xC0000000.
- R2: A zero exponent with a zero fraction gives a signed zero: 0x0000 gives 0x00000000 and 0x8000 gives 0x80000000.
- R3: A zero exponent with a non-zero fraction (a subnormal) is normalised. If p is the bit index of the highest set fraction bit, the output exponent is 103+p and the fraction bits below that leading one go to the top of the output fraction. Examples: 0x0001 gives 0x33800000 and 0x03FF gives 0x387FC000.
- R4: In standard mode (ext_range = 0), an exponent of 31 with a zero fraction gives a signed infinity: 0x7C00 gives 0x7F800000 and 0xFC00 gives 0xFF800000.
- R5: In standard mode, an exponent of 31 with a non-zero fraction gives a NaN with the same sign. Output exponent bits are all ones, the input fraction is copied to output bits 22:13, and bit 22 is forced to 1. Examples: 0x7C01 gives 0x7FC02000 and 0xFE00 gives 0xFFC00000.
- R6: In extended-range mode (ext_range = 1), exponent 31 is decoded as a normal exponent (biased 143). Examples: 0x7C00 gives 0x47800000 and 0x7FFF gives 0x47FFE000. In this mode no output has an all-ones exponent.
- R7: For inputs whose exponent is 0..30, ext_range has no effect on the output.
- R8: With the output register enabled (the default), the output shows the conversion of the inputs present at the previous rising clock edge and holds between edges. While rst_n is low the output is 0x00000000.
- R9: Output bit 31 always equals input bit 15 for every input class and mode; for example, 0x8001 gives 0xB3800000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| ext_range | input | 1 | 1 selects the extended-range half format, 0 the standard format |
| half_in | input | 16 | Half-precision operand |
| single_out | output | 32 | Single-precision result |

## Verification
The bound checker checks the class-level invariants on every clock. It checks that the sign carries through, that normal inputs get the re-biased exponent and the aligned fraction with zero low bits, and that subnormals land in the exponent window 103..112. It also checks the infinity and quiet-NaN encodings in standard mode, that no all-ones exponent appears in extended-range mode, and that zeros clear every bit except the sign. Only the bench's scenarios show the exact shifted fraction bits of each subnormal, the register latency and the reset value, and the mode-independence for ordinary exponents. The bench covers these with an exhaustive sweep of all 65,536 codes in both modes, randomly ordered traffic with mode toggling, and paired mode comparisons.

// File: rtl/fp16_widen_pkg.sv
package fp16_widen_pkg;

   // Decoded class of the narrow operand
   typedef enum logic [2:0] {
      HCLS_ZERO = 3'd0,
      HCLS_SUB  = 3'd1,
      HCLS_NORM = 3'd2,
      HCLS_INF  = 3'd3,
      HCLS_NAN  = 3'd4
   } hcls_t;

   // Exponent bias of an IEEE-style field of the given width
   function automatic int bias_of(input int exp_w);
      return (1 << (exp_w - 1)) - 1;
   endfunction

endpackage

// File: rtl/fp16_widen_classify.sv
module fp16_widen_classify
   import fp16_widen_pkg::*;
#(
   parameter int EXP_W  = 5,
   parameter int FRAC_W = 10,
   localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic              ext_range_i,
   output logic              sign_o,
   output logic [EXP_W-1:0]  exp_o,
   output logic [FRAC_W-1:0] frac_o,
   output hcls_t             cls_o
);

   logic exp_zero;
   logic exp_full;
   logic frac_zero;

   assign sign_o = word_i[WORD_W-1];
   assign exp_o  = word_i[WORD_W-2 -: EXP_W];
   assign frac_o = word_i[FRAC_W-1:0];

   assign exp_zero  = (exp_o == '0);
   assign exp_full  = &exp_o;
   assign frac_zero = (frac_o == '0);

   always_comb begin
      if (exp_zero) begin
         cls_o = frac_zero ? HCLS_ZERO : HCLS_SUB;
      end else if (exp_full && !ext_range_i) begin
         cls_o = frac_zero ? HCLS_INF : HCLS_NAN;
      end else begin
         cls_o = HCLS_NORM;
      end
   end

endmodule

// File: rtl/fp16_widen_normalise.sv
module fp16_widen_normalise #(
   parameter int FRAC_W = 10,
   localparam int POS_W = $clog2(FRAC_W + 1)
) (
   input  logic [FRAC_W-1:0] frac_i,
   output logic [POS_W-1:0]  lead_o,
   output logic [FRAC_W-1:0] tail_o
);

   // Priority search: the last set bit seen while scanning upward wins
   always_comb begin
      lead_o = '0;
      for (int i = 0; i < FRAC_W; i++) begin
         if (frac_i[i]) begin
            lead_o = POS_W'(i);
         end
      end
   end

   // Shift the leading one just past the top so that only the bits below it remain
   logic [2*FRAC_W-1:0] shifted;
   assign shifted = {{FRAC_W{1'b0}}, frac_i} << (FRAC_W - int'(lead_o));
   assign tail_o  = shifted[FRAC_W-1:0];

endmodule

// File: rtl/fp16_widen_pack.sv
module fp16_widen_pack
   import fp16_widen_pkg::*;
#(
   parameter int EXP_IN_W   = 5,
   parameter int FRAC_IN_W  = 10,
   parameter int EXP_OUT_W  = 8,
   parameter int FRAC_OUT_W = 23,
   localparam int POS_W  = $clog2(FRAC_IN_W + 1),
   localparam int OUT_W  = 1 + EXP_OUT_W + FRAC_OUT_W,
   localparam int PAD_W  = FRAC_OUT_W - FRAC_IN_W,
   localparam int DELTA  = bias_of(EXP_OUT_W) - bias_of(EXP_IN_W),
   localparam int SUB_LO = DELTA + 1 - FRAC_IN_W
) (
   input  hcls_t                sign_cls_dummy_unused_never,
   input  hcls_t                cls_i,
   input  logic                 sign_i,
   input  logic [EXP_IN_W-1:0]  exp_i,
   input  logic [FRAC_IN_W-1:0] frac_i,
   input  logic [POS_W-1:0]     lead_i,
   input  logic [FRAC_IN_W-1:0] tail_i,
   output logic [OUT_W-1:0]     word_o
);

   logic [EXP_OUT_W-1:0]  exp_w;
   logic [FRAC_OUT_W-1:0] frac_w;
   logic                  unused_in;

   assign unused_in = ^sign_cls_dummy_unused_never;

   always_comb begin
      exp_w  = '0;
      frac_w = '0;
      unique case (cls_i)
         HCLS_SUB: begin
            exp_w  = EXP_OUT_W'(SUB_LO) + EXP_OUT_W'(lead_i);
            frac_w = {tail_i, {PAD_W{1'b0}}};
         end
         HCLS_NORM: begin
            exp_w  = EXP_OUT_W'(exp_i) + EXP_OUT_W'(DELTA);
            frac_w = {frac_i, {PAD_W{1'b0}}};
         end
         HCLS_INF: begin
            exp_w  = '1;
            frac_w = '0;
         end
         HCLS_NAN: begin
            exp_w  = '1;
            frac_w = {frac_i, {PAD_W{1'b0}}};
            frac_w[FRAC_OUT_W-1] = 1'b1;
         end
         default: begin
            exp_w  = '0;
            frac_w = '0;
         end
      endcase
   end

   assign word_o = {sign_i, exp_w, frac_w};

endmodule

// File: rtl/fp16_to_fp32_widen.sv
module fp16_to_fp32_widen
   import fp16_widen_pkg::*;
#(
   parameter int EXP_IN_W   = 5,
   parameter int FRAC_IN_W  = 10,
   parameter int EXP_OUT_W  = 8,
   parameter int FRAC_OUT_W = 23,
   parameter bit REG_OUT    = 1'b1,
   localparam int IN_W  = 1 + EXP_IN_W + FRAC_IN_W,
   localparam int OUT_W = 1 + EXP_OUT_W + FRAC_OUT_W,
   localparam int POS_W = $clog2(FRAC_IN_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_range,
   input  logic [IN_W-1:0]  half_in,
   output logic [OUT_W-1:0] single_out
);

   localparam int BIAS_IN  = bias_of(EXP_IN_W);
   localparam int BIAS_OUT = bias_of(EXP_OUT_W);
   localparam int TOP_EXT  = (1 << EXP_IN_W) - 1 - BIAS_IN;
   localparam int LOW_SUB  = 1 - BIAS_IN - FRAC_IN_W;

   // Elaboration-time checks that the wide format holds every narrow value exactly
   if (FRAC_OUT_W <= FRAC_IN_W) begin : g_bad_frac
      $error("wide fraction must be longer than the narrow fraction");
   end
   if (TOP_EXT > BIAS_OUT) begin : g_bad_top
      $error("wide exponent cannot reach the extended narrow range");
   end
   if (LOW_SUB < 1 - BIAS_OUT) begin : g_bad_low
      $error("wide exponent cannot hold the smallest narrow subnormal");
   end

   logic                 f_sign;
   logic [EXP_IN_W-1:0]  f_exp;
   logic [FRAC_IN_W-1:0] f_frac;
   hcls_t                f_cls;
   logic [POS_W-1:0]     n_lead;
   logic [FRAC_IN_W-1:0] n_tail;
   logic [OUT_W-1:0]     packed_w;

   fp16_widen_classify #(
      .EXP_W  (EXP_IN_W),
      .FRAC_W (FRAC_IN_W)
   ) u_classify (
      .word_i      (half_in),
      .ext_range_i (ext_range),
      .sign_o      (f_sign),
      .exp_o       (f_exp),
      .frac_o      (f_frac),
      .cls_o       (f_cls)
   );

   fp16_widen_normalise #(
      .FRAC_W (FRAC_IN_W)
   ) u_normalise (
      .frac_i (f_frac),
      .lead_o (n_lead),
      .tail_o (n_tail)
   );

   fp16_widen_pack #(
      .EXP_IN_W   (EXP_IN_W),
      .FRAC_IN_W  (FRAC_IN_W),
      .EXP_OUT_W  (EXP_OUT_W),
      .FRAC_OUT_W (FRAC_OUT_W)
   ) u_pack (
      .sign_cls_dummy_unused_never (HCLS_ZERO),
      .cls_i   (f_cls),
      .sign_i  (f_sign),
      .exp_i   (f_exp),
      .frac_i  (f_frac),
      .lead_i  (n_lead),
      .tail_i  (n_tail),
      .word_o  (packed_w)
   );

   if (REG_OUT) begin : g_reg
      logic [OUT_W-1:0] out_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_q <= '0;
         end else begin
            out_q <= packed_w;
         end
      end
      assign single_out = out_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign single_out = packed_w;
   end

endmodule

// File: rtl/fp16_to_fp32_widen_chk.sv
module fp16_to_fp32_widen_chk #(
   parameter int EXP_IN_W   = 5,
   parameter int FRAC_IN_W  = 10,
   parameter int EXP_OUT_W  = 8,
   parameter int FRAC_OUT_W = 23,
   parameter bit REG_OUT    = 1'b1,
   localparam int IN_W  = 1 + EXP_IN_W + FRAC_IN_W,
   localparam int OUT_W = 1 + EXP_OUT_W + FRAC_OUT_W,
   localparam int PAD_W = FRAC_OUT_W - FRAC_IN_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ext_range,
   input logic [IN_W-1:0]  half_in,
   input logic [OUT_W-1:0] single_out
);

   localparam int DELTA  = ((1 << (EXP_OUT_W - 1)) - 1) - ((1 << (EXP_IN_W - 1)) - 1);
   localparam int SUB_LO = DELTA + 1 - FRAC_IN_W;
   localparam int SUB_HI = DELTA;

   // Inputs aligned to the cycle the output belongs to
   logic [IN_W-1:0] src_in;
   logic            src_mode;
   logic            src_ok;

   if (REG_OUT) begin : g_lat
      logic [IN_W-1:0] hist_in;
      logic            hist_mode;
      logic            hist_ok;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hist_in   <= '0;
            hist_mode <= 1'b0;
            hist_ok   <= 1'b0;
         end else begin
            hist_in   <= half_in;
            hist_mode <= ext_range;
            hist_ok   <= 1'b1;
         end
      end
      assign src_in   = hist_in;
      assign src_mode = hist_mode;
      assign src_ok   = hist_ok;
   end else begin : g_now
      assign src_in   = half_in;
      assign src_mode = ext_range;
      assign src_ok   = 1'b1;
   end

   logic                  s_sign;
   logic [EXP_IN_W-1:0]   s_exp;
   logic [FRAC_IN_W-1:0]  s_frac;
   logic                  o_sign;
   logic [EXP_OUT_W-1:0]  o_exp;
   logic [FRAC_OUT_W-1:0] o_frac;

   assign s_sign = src_in[IN_W-1];
   assign s_exp  = src_in[IN_W-2 -: EXP_IN_W];
   assign s_frac = src_in[FRAC_IN_W-1:0];
   assign o_sign = single_out[OUT_W-1];
   assign o_exp  = single_out[OUT_W-2 -: EXP_OUT_W];
   assign o_frac = single_out[FRAC_OUT_W-1:0];

   assert_sign_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      src_ok |-> (o_sign == s_sign));

   assert_normal_rebias_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (src_ok && s_exp != '0 && (!(&s_exp) || src_mode))
      |-> (int'(o_exp) == int'(s_exp) + DELTA
           && o_frac[FRAC_OUT_W-1 -: FRAC_IN_W] == s_frac
           && o_frac[PAD_W-1:0] == '0));

   assert_zero_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (src_ok && s_exp == '0 && s_frac == '0) |-> (single_out[OUT_W-2:0] == '0));

   assert_sub_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (src_ok && s_exp == '0 && s_frac != '0)
      |-> (int'(o_exp) >= SUB_LO && int'(o_exp) <= SUB_HI && o_frac[PAD_W-1:0] == '0));

   assert_std_inf_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (src_ok && !src_mode && (&s_exp) && s_frac == '0)
      |-> ((&o_exp) && o_frac == '0));

   assert_std_nan_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (src_ok && !src_mode && (&s_exp) && s_frac != '0)
      |-> ((&o_exp) && o_frac[FRAC_OUT_W-1]
           && o_frac[FRAC_OUT_W-2 -: (FRAC_IN_W-1)] == s_frac[FRAC_IN_W-2:0]));

   assert_ext_no_special_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (src_ok && src_mode) |-> !(&o_exp));

endmodule

bind fp16_to_fp32_widen fp16_to_fp32_widen_chk #(
   .EXP_IN_W   (EXP_IN_W),
   .FRAC_IN_W  (FRAC_IN_W),
   .EXP_OUT_W  (EXP_OUT_W),
   .FRAC_OUT_W (FRAC_OUT_W),
   .REG_OUT    (REG_OUT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ext_range  (ext_range),
   .half_in    (half_in),
   .single_out (single_out)
);

// File: tb/fp16_to_fp32_widen_test.sv
module fp16_to_fp32_widen_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_range = 1'b0;
   logic [15:0] half_in = '0;
   logic [31:0] single_out;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   always #10 clk = ~clk;   // 50 MHz

   fp16_to_fp32_widen uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ext_range  (ext_range),
      .half_in    (half_in),
      .single_out (single_out)
   );

   // Value model written from the requirements: scale a subnormal up until its leading one appears
   function automatic logic [31:0] model(input logic [15:0] h, input logic alt);
      logic s;
      int   e;
      int   m;
      int   ee;
      s = h[15];
      e = int'(h[14:10]);
      m = int'(h[9:0]);
      if (e == 31 && !alt) begin
         if (m == 0) return {s, 8'hFF, 23'h0};
         return {s, 8'hFF, 23'(m << 13) | 23'h400000};
      end
      if (e == 0) begin
         if (m == 0) return {s, 31'h0};
         ee = -14;
         while (m < 1024) begin
            m  = m * 2;
            ee = ee - 1;
         end
         return {s, 8'(ee + 127), 23'((m - 1024) << 13)};
      end
      return {s, 8'(e + 112), 23'(m << 13)};
   endfunction

   function automatic string tag_of(input logic [15:0] h, input logic alt);
      if (h[14:10] == 5'd0) return (h[9:0] == 0) ? "R2" : "R3";
      if (h[14:10] == 5'd31) begin
         if (alt) return "R6";
         return (h[9:0] == 0) ? "R4" : "R5";
      end
      return "R1";
   endfunction

   task automatic check(input logic [31:0] act, input logic [31:0] expv, input string req);
      n_checks++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, expv);
      end
   endtask

   // Drive on the falling edge, read just after the next rising edge
   task automatic apply(input logic [15:0] h, input logic alt, output logic [31:0] got);
      @(negedge clk);
      half_in   = h;
      ext_range = alt;
      @(posedge clk);
      #5;
      got = single_out;
   endtask

   task automatic directed(input logic [15:0] h, input logic alt, input logic [31:0] expv,
                           input string req);
      logic [31:0] got;
      apply(h, alt, got);
      check(got, expv, req);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
      end
   end

   initial begin
      logic [31:0] got;
      logic [31:0] a;
      logic [31:0] b;
      void'($urandom(32'd4242));

      // R8: reset value, even with a live input present
      half_in = 16'h3C00;
      repeat (3) @(posedge clk);
      #5;
      check(single_out, 32'h0, "R8 reset");
      @(negedge clk);
      rst_n = 1'b1;

      // Directed corner cases
      directed(16'h3C00, 1'b0, 32'h3F800000, "R1");
      directed(16'h7BFF, 1'b0, 32'h477FE000, "R1");
      directed(16'hC000, 1'b0, 32'hC0000000, "R1");
      directed(16'h0400, 1'b0, 32'h38800000, "R1");
      directed(16'h0000, 1'b0, 32'h00000000, "R2");
      directed(16'h8000, 1'b1, 32'h80000000, "R2");
      directed(16'h0001, 1'b0, 32'h33800000, "R3");
      directed(16'h03FF, 1'b0, 32'h387FC000, "R3");
      directed(16'h7C00, 1'b0, 32'h7F800000, "R4");
      directed(16'hFC00, 1'b0, 32'hFF800000, "R4");
      directed(16'h7C01, 1'b0, 32'h7FC02000, "R5");
      directed(16'hFE00, 1'b0, 32'hFFC00000, "R5");
      directed(16'h7C00, 1'b1, 32'h47800000, "R6");
      directed(16'h7FFF, 1'b1, 32'h47FFE000, "R6");
      directed(16'h8001, 1'b0, 32'hB3800000, "R9");

      // R8: output holds until the next rising edge
      directed(16'h3C00, 1'b0, 32'h3F800000, "R8");
      @(negedge clk);
      half_in = 16'hC000;
      #5;
      check(single_out, 32'h3F800000, "R8 hold");
      @(posedge clk);
      #5;
      check(single_out, 32'hC0000000, "R8 update");

      // Exhaustive sweep of both formats
      for (int md = 0; md < 2; md++) begin
         for (int h = 0; h < 65536; h++) begin
            apply(16'(h), md[0], got);
            check(got, model(16'(h), md[0]), tag_of(16'(h), md[0]));
         end
      end

      // Random traffic with the mode toggling
      for (int i = 0; i < 3000; i++) begin
         logic [15:0] h;
         logic        md;
         h  = 16'($urandom);
         md = 1'($urandom);
         apply(h, md, got);
         check(got, model(h, md), tag_of(h, md));
         check({31'h0, got[31]}, {31'h0, h[15]}, "R9");
      end

      // R7: mode has no effect below the all-ones exponent
      for (int i = 0; i < 500; i++) begin
         logic [15:0] h;
         h = 16'($urandom);
         if (h[14:10] == 5'd31) h[14] = 1'b0;
         apply(h, 1'b0, a);
         apply(h, 1'b1, b);
         check(b, a, "R7");
      end

      finished = 1;
      summary();
   end

endmodule